// File: doc/BRIEF.md
# Command Register Handshake Unit

This unit sits between a host and a communication engine. The host issues a command through a single 16-bit register write. That one write carries the opcode, a channel number, an optional engine-reset request and a busy flag. The unit checks the write and, if it is legal, latches it. It then hands the opcode and channel to the engine with a one-cycle strobe, and keeps the busy flag set until the engine reports completion. The host learns that the command has finished by polling the busy flag.

Writes that set reserved bits are refused. Writes that arrive while a command is still in flight are dropped. Both cases leave a sticky status bit behind. A watchdog raises a timeout flag if the busy flag stays set past a configurable number of cycles. This mirrors a host that gives up after a fixed number of polls.

The engine is a simple responder that completes after a number of cycles set by the opcode. A reset command re-initialises the engine. When it completes, the register, the sticky status bits and the per-channel completion record all return to their idle values.

Register layout:

| Bits | Field |
|------|-------|
| 15:8 | opcode |
| 7:4 | channel |
| 3:2 | reserved, must be zero |
| 1 | engine reset request |
| 0 | busy flag |

Top module: `cmd_hs_unit`

## Requirements
- R1: After reset, the register reads 0. The strobe, done, overrun, reject and timeout outputs are 0, and every bit of the per-channel completion vector is 0.
- R2: A write is accepted when it arrives while the busy flag (bit 0) is clear, has bit 0 set, and has the reserved bits 3:2 at zero. An accepted write latches opcode 15:8 and channel 7:4 and sets the busy flag. One cycle later the engine strobe pulses for exactly one cycle, carrying that opcode and channel.
- R3: For a normal command, the engine takes L cycles, where L is the opcode value, or 1 when the opcode is 0. The busy flag reads clear exactly L+2 clock edges after the accepting edge. The done output is high only while the busy flag is set.
- R4: A write with either reserved bit (3 or 2) set, arriving while the unit is not busy, is rejected. No strobe is issued, the register is unchanged, and the sticky reject output is set.
- R5: A write arriving while the busy flag is set is ignored. The opcode and channel fields keep their values, and the sticky overrun output is set.
- R6: A write with bit 0 clear and reserved bits zero is discarded. No strobe is issued, and the register and status outputs are unchanged.
- R7: An accepted write with bit 1 set is an engine reset. The strobe carries the reset indication, and the busy flag clears RST_LAT+2 edges after acceptance. On completion, the register, overrun, reject, timeout and the per-channel completion vector all read 0.
- R8: If the busy flag stays set for TIMEOUT_LIMIT edges after acceptance without completing, the timeout output rises while busy is still set. A command that completes exactly on edge TIMEOUT_LIMIT does not time out. The timeout output is cleared by the next accepted command.
- R9: When a normal command completes, bit `channel` of the per-channel completion vector is set, on the same edge that clears the busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Current command register contents |
| cmd_strobe_o | output | 1 | One-cycle command strobe to the engine |
| cmd_op_o | output | 8 | Opcode presented with the strobe |
| cmd_chan_o | output | 4 | Channel presented with the strobe |
| cmd_rst_o | output | 1 | Engine reset indication presented with the strobe |
| done_o | output | 1 | Engine completion pulse |
| overrun_o | output | 1 | Sticky: write arrived while busy |
| reject_o | output | 1 | Sticky: write carried reserved bits |
| timeout_o | output | 1 | Busy flag held past the timeout limit |
| chan_done_o | output | 16 | Per-channel record of completed commands |

## Verification
Several behaviours are checked on every cycle:
- the strobe is a single pulse that follows every legal write;
- the busy flag cannot drop without a done pulse;
- done never occurs while idle;
- the overrun and reject bits stick, and a write while busy sets overrun;
- reset completion clears all state.

Some behaviours only the bench scenarios can show:
- the exact opcode-dependent completion latency;
- the edge at which the timeout rises, compared with a command that ends exactly at the limit;
- the accumulated per-channel completion vector across a sequence of commands.

// File: rtl/cmd_hs_pkg.sv
// Package: shared field layout and command word type for the command
// register handshake unit. Assumes a 16-bit register with the opcode in
// the top byte.
package cmd_hs_pkg;
    localparam int OP_W   = 8;
    localparam int CH_W   = 4;
    localparam int RSV_W  = 2;
    localparam int CMD_W  = OP_W + CH_W + RSV_W + 2;
    localparam int NCH    = 1 << CH_W;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [CH_W-1:0]  chan;
        logic [RSV_W-1:0] rsv;
        logic             rst;
        logic             busy;
    } cmd_word_t;
endpackage

// File: rtl/cmd_hs_decode.sv
// Module: write classifier. Sorts a host write into accept, reject,
// overrun or silent discard from the current busy state.
// Assumes the caller holds the busy flag in a register.
module cmd_hs_decode
    import cmd_hs_pkg::*;
(
    input  logic      wr_en,
    input  cmd_word_t wr_word,
    input  logic      busy,
    output logic      accept,
    output logic      reject,
    output logic      overrun_ev
);
    logic rsv_bad;

    // Flag any reserved bit set in the written word.
    always_comb begin
        rsv_bad    = |wr_word.rsv;
        overrun_ev = wr_en & busy;
        reject     = wr_en & ~busy & rsv_bad;
        accept     = wr_en & ~busy & ~rsv_bad & wr_word.busy;
    end
endmodule

// File: rtl/cmd_hs_engine_model.sv
// Module: stand-in communication engine. After a start strobe it waits
// a latency cycles and then pulses done for one cycle.
// The latency is the opcode value (minimum 1), or RST_LAT for a reset.
// Assumes no new start arrives while a command is running.
module cmd_hs_engine_model
    import cmd_hs_pkg::*;
#(
    parameter int RST_LAT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_rst,
    input  logic [OP_W-1:0] opcode,
    output logic            done
);
    localparam int RST_W = $clog2(RST_LAT + 1);
    localparam int CNT_W = (OP_W > RST_W) ? OP_W : RST_W;

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [CNT_W-1:0] lat;

    // Select the latency for the command being started.
    always_comb begin
        if (start_rst)
            lat = CNT_W'(RST_LAT);
        else if (opcode == '0)
            lat = CNT_W'(1);
        else
            lat = CNT_W'(opcode);
    end

    // Count the latency down and emit a single done pulse at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                cnt_q    <= lat;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cmd_hs_watchdog.sv
// Module: busy-time watchdog. Counts the cycles the busy flag has been
// held. It raises a timeout when TIMEOUT_LIMIT edges pass without a
// completion. Assumes clear pulses on every accepted command.
module cmd_hs_watchdog #(
    parameter int TIMEOUT_LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy,
    input  logic done,
    output logic timeout
);
    localparam int TO_W = $clog2(TIMEOUT_LIMIT + 1);

    logic [TO_W-1:0] cnt_q;

    // Track busy time and latch the timeout until the next clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
        end else if (clear) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
        end else if (busy && !timeout) begin
            cnt_q <= cnt_q + TO_W'(1);
            if (!done && cnt_q == TO_W'(TIMEOUT_LIMIT - 1))
                timeout <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_hs_chan_state.sv
// Module: per-channel completion record. One flag per channel is set
// when a command for that channel completes, and all flags clear
// together on an engine reset. Assumes set and clear never coincide.
module cmd_hs_chan_state
    import cmd_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [CH_W-1:0] set_chan,
    input  logic            clr_all,
    output logic [NCH-1:0]  flags
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Hold the completion flag of one channel.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)
                flags[g] <= 1'b0;
            else if (set_en && set_chan == CH_W'(g))
                flags[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/cmd_hs_unit.sv
// Module: top of the command register handshake unit. It holds the host
// command register, validates writes, strobes the engine, clears the
// busy flag on completion and keeps the sticky status bits.
// Assumes a single host writer and synchronous active-low reset.
module cmd_hs_unit
    import cmd_hs_pkg::*;
#(
    parameter int TIMEOUT_LIMIT = 10000,
    parameter int RST_LAT       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output logic [CMD_W-1:0] rd_data,
    output logic             cmd_strobe_o,
    output logic [OP_W-1:0]  cmd_op_o,
    output logic [CH_W-1:0]  cmd_chan_o,
    output logic             cmd_rst_o,
    output logic             done_o,
    output logic             overrun_o,
    output logic             reject_o,
    output logic             timeout_o,
    output logic [NCH-1:0]   chan_done_o
);
    cmd_word_t wr_word;
    cmd_word_t reg_q;
    logic      accept, reject_ev, overrun_ev;
    logic      strobe_q;
    logic      eng_done;
    logic      rst_done;
    logic      cmd_done;

    assign wr_word  = cmd_word_t'(wr_data);
    assign rst_done = eng_done & reg_q.busy & reg_q.rst;
    assign cmd_done = eng_done & reg_q.busy & ~reg_q.rst;

    cmd_hs_decode u_dec (
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .busy       (reg_q.busy),
        .accept     (accept),
        .reject     (reject_ev),
        .overrun_ev (overrun_ev)
    );

    // Command register: load on accept, drop busy on done, clear on reset done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (accept) begin
            reg_q      <= wr_word;
            reg_q.busy <= 1'b1;
        end else if (rst_done) begin
            reg_q <= '0;
        end else if (cmd_done) begin
            reg_q.busy <= 1'b0;
        end
    end

    // Engine strobe: a single pulse one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b0;
        else
            strobe_q <= accept;
    end

    // Sticky status bits: set by their events, cleared by reset completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun_o <= 1'b0;
            reject_o  <= 1'b0;
        end else begin
            if (rst_done) begin
                overrun_o <= 1'b0;
                reject_o  <= 1'b0;
            end
            if (overrun_ev)
                overrun_o <= 1'b1;
            if (reject_ev)
                reject_o <= 1'b1;
        end
    end

    cmd_hs_engine_model #(.RST_LAT(RST_LAT)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (strobe_q),
        .start_rst (reg_q.rst),
        .opcode    (reg_q.op),
        .done      (eng_done)
    );

    cmd_hs_watchdog #(.TIMEOUT_LIMIT(TIMEOUT_LIMIT)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept | rst_done),
        .busy    (reg_q.busy),
        .done    (eng_done),
        .timeout (timeout_o)
    );

    cmd_hs_chan_state u_chs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cmd_done),
        .set_chan (reg_q.chan),
        .clr_all  (rst_done),
        .flags    (chan_done_o)
    );

    assign rd_data      = reg_q;
    assign cmd_strobe_o = strobe_q;
    assign cmd_op_o     = reg_q.op;
    assign cmd_chan_o   = reg_q.chan;
    assign cmd_rst_o    = reg_q.rst;
    assign done_o       = eng_done;
endmodule

// File: rtl/cmd_hs_checker.sv
// Module: property checker for cmd_hs_unit, attached with bind.
// It observes only the ports of the unit.
module cmd_hs_checker #(
    parameter int NCH = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [15:0]    wr_data,
    input logic [15:0]    rd_data,
    input logic           cmd_strobe_o,
    input logic [7:0]     cmd_op_o,
    input logic           done_o,
    input logic           overrun_o,
    input logic           reject_o,
    input logic           timeout_o,
    input logic [NCH-1:0] chan_done_o
);
    p_strobe_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_data[0] && wr_data[0] && wr_data[3:2] == 2'b00
        |=> cmd_strobe_o && cmd_op_o == $past(wr_data[15:8]));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o |=> !cmd_strobe_o);

    p_busy_until_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && !done_o |=> rd_data[0]);

    p_done_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rd_data[0]);

    p_done_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !rd_data[0]);

    p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_data[0] && wr_data[3:2] != 2'b00 |=> reject_o && !cmd_strobe_o);

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && rd_data[0] |=> overrun_o && $stable(rd_data[15:4]));

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o && !(done_o && rd_data[1]) |=> overrun_o);

    p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !rd_data[0] && !wr_data[0] && wr_data[3:2] == 2'b00
        |=> !cmd_strobe_o && $stable(rd_data) && $stable(reject_o));

    p_reset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && rd_data[1] && !wr_en
        |=> rd_data == 16'h0000 && chan_done_o == '0 && !overrun_o && !reject_o && !timeout_o);

    p_timeout_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> rd_data[0]);

    p_chan_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !rd_data[1] |=> chan_done_o[$past(rd_data[7:4])]);
endmodule

bind cmd_hs_unit cmd_hs_checker #(.NCH(16)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .cmd_strobe_o (cmd_strobe_o),
    .cmd_op_o     (cmd_op_o),
    .done_o       (done_o),
    .overrun_o    (overrun_o),
    .reject_o     (reject_o),
    .timeout_o    (timeout_o),
    .chan_done_o  (chan_done_o)
);

// File: tb/tb_cmd_hs_unit.sv
`timescale 1ns/1ps
module tb_cmd_hs_unit;
    localparam int LIMIT = 40;
    localparam int RLAT  = 6;
    localparam int NVEC  = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0001, 16'h0311, 16'h05A1, 16'h0AF1, 16'h1C71, 16'h2651
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cmd_strobe_o, cmd_rst_o, done_o;
    logic [7:0]  cmd_op_o;
    logic [3:0]  cmd_chan_o;
    logic        overrun_o, reject_o, timeout_o;
    logic [15:0] chan_done_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_cd = '0;

    always #2.5 clk = ~clk;

    cmd_hs_unit #(.TIMEOUT_LIMIT(LIMIT), .RST_LAT(RLAT)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cmd_strobe_o(cmd_strobe_o), .cmd_op_o(cmd_op_o),
        .cmd_chan_o(cmd_chan_o), .cmd_rst_o(cmd_rst_o), .done_o(done_o),
        .overrun_o(overrun_o), .reject_o(reject_o), .timeout_o(timeout_o),
        .chan_done_o(chan_done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge just after the accepting edge.
    task automatic host_write(input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    // Count edges after the write edge until busy reads clear.
    task automatic wait_idle(output int n);
        n = 0;
        while (rd_data[0] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle values after reset
        chk("R1 reg", rd_data, 16'h0);
        chk("R1 status", {cmd_strobe_o, done_o, overrun_o, reject_o, timeout_o}, 0);
        chk("R1 chan", chan_done_o, 16'h0);

        // Table walk: R2 strobe, R3 latency, R9 channel record
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] op;
            logic [3:0] ch;
            int lat;
            op  = VEC[i][15:8];
            ch  = VEC[i][7:4];
            lat = (op == 0) ? 1 : int'(op);
            host_write(VEC[i]);
            chk("R2 strobe", {cmd_strobe_o, cmd_op_o, cmd_chan_o}, {1'b1, op, ch});
            chk("R2 busy", rd_data[0], 1'b1);
            @(negedge clk);
            chk("R2 single pulse", cmd_strobe_o, 1'b0);
            n = 1;
            while (rd_data[0] && n < 2000) begin
                @(negedge clk);
                n++;
            end
            chk("R3 latency", n, lat + 2);
            exp_cd[ch] = 1'b1;
            chk("R9 chan record", chan_done_o, exp_cd);
            chk("R8 no timeout at or under limit", timeout_o, 1'b0);
        end

        // R6: busy bit clear, reserved clear -> discarded
        host_write(16'h1230);
        chk("R6 no strobe", cmd_strobe_o, 1'b0);
        chk("R6 reg unchanged", rd_data, 16'h2650);
        chk("R6 status", {overrun_o, reject_o}, 0);

        // R4: reserved bit set -> rejected
        host_write(16'h0305);
        chk("R4 no strobe", cmd_strobe_o, 1'b0);
        chk("R4 reg unchanged", rd_data, 16'h2650);
        chk("R4 reject", reject_o, 1'b1);

        // R5: write while busy ignored
        host_write(16'h1011);
        host_write(16'h0221);
        chk("R5 fields kept", rd_data[15:4], 12'h101);
        chk("R5 overrun", overrun_o, 1'b1);
        wait_idle(n);
        exp_cd[1] = 1'b1;
        chk("R5 overrun sticky", overrun_o, 1'b1);

        // R8: opcode 39 -> 41 edges, exceeds limit 40
        host_write(16'h2731);
        repeat (LIMIT - 1) @(negedge clk);
        chk("R8 before limit", timeout_o, 1'b0);
        @(negedge clk);
        chk("R8 at limit", {timeout_o, rd_data[0]}, 2'b11);
        wait_idle(n);
        exp_cd[3] = 1'b1;
        chk("R8 sticky after done", timeout_o, 1'b1);
        host_write(16'h0041);
        chk("R8 cleared by accept", timeout_o, 1'b0);
        wait_idle(n);
        exp_cd[4] = 1'b1;
        chk("R9 accumulated", chan_done_o, exp_cd);

        // R7: engine reset command
        host_write(16'h0003);
        chk("R7 strobe rst", {cmd_strobe_o, cmd_rst_o}, 2'b11);
        n = 0;
        while (rd_data[0] && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 latency", n, RLAT + 2);
        chk("R7 reg cleared", rd_data, 16'h0);
        chk("R7 chan cleared", chan_done_o, 16'h0);
        chk("R7 status cleared", {overrun_o, reject_o, timeout_o}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule